// File: doc/BRIEF.md
# Selectable System and Timer Clock Enable Divider

This block sits in the oscillator clock domain and turns that clock into two enable strobes: one for the processor logic (the system enable) and one for the counter/timers and interrupt logic (the timer enable). Each strobe is high for one oscillator cycle at its divided rate. The design works only with enables in a single clock domain and never creates a derived clock net.

A small configuration register, written through a one-cycle write strobe, sets the rate. One field selects a base divide of two or pass-through at the full oscillator rate. Two independent bits each add a divide-by-16 prescaler, one for the system domain and one for the timer domain, so each domain can run at 1, 2, 16 or 32 oscillator cycles per strobe. A power-mode input gates the strobes. In run mode both strobes are active. In halt mode only the timer strobe runs. In stop mode and in standby mode neither strobe runs.

A new divide setting never cuts short an interval already in progress. Each domain takes up a new setting only when its own divider wraps, or while the domain is gated. When a gated domain resumes, its divider starts again from zero.

Top module: `clkgen_top`

## Requirements
- R1: After reset the configuration register is all zero, no strobe is high while reset is held, and both strobes then repeat every 2 cycles.
- R2: With configuration bit 1 set to one (bits 2 and 3 zero), both strobes fire in every cycle.
- R3: With configuration bit 1 zero, bit 0 has no effect: the value 4'b0001 gives the same 2-cycle period on both strobes as 4'b0000.
- R4: Configuration bit 2 multiplies the system strobe period by 16 (32 cycles with bit 1 zero, 16 with bit 1 one). The timer strobe is not affected.
- R5: Configuration bit 3 multiplies the timer strobe period by 16 (32 cycles with bit 1 zero, 16 with bit 1 one). The system strobe is not affected.
- R6: In run mode (pwr_mode_i = 2'b00) both strobes fire at their configured rates.
- R7: In halt mode (pwr_mode_i = 2'b01) the system strobe stays low, while the timer strobe keeps its configured rate.
- R8: In stop mode (2'b10) and in standby mode (2'b11) both strobes stay low.
- R9: Whenever the period is larger than 1, a strobe is high for exactly one cycle.
- R10: A write to the configuration takes effect in a domain only at that domain's next divider wrap. The interval in progress finishes with the old period.
- R11: When a gated domain returns to an active mode, its divider restarts from zero with the current configuration. The first strobe comes period-1 cycles after the cycle in which the mode changes, with that cycle counted as cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 4 | Configuration data: [1:0] base divide, [2] system prescale, [3] timer prescale |
| pwr_mode_i | input | 2 | Power mode: 00 run, 01 halt, 10 stop, 11 standby |
| sys_en_o | output | 1 | One-cycle system enable strobe |
| tmr_en_o | output | 1 | One-cycle timer enable strobe |

## Verification
A configuration write can arrive in the same cycle as a divider wrap, or partway through a long interval. The bench provokes the second case by writing a fast setting in the cycle right after a 32-cycle strobe. It then checks that the interval in progress still measures 32 and that the next interval uses the new rate. A mode change and a pending setting can also meet at the moment of resume: the bench writes a new prescale while halted, returns to run, and checks that the first system strobe appears after exactly the new period minus one.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  localparam int BASE_RATIO = 2;
  localparam int PRE_RATIO  = 16;
  localparam int CFG_W      = 4;
  localparam int NDOM       = 2;
  localparam int MAX_PER    = BASE_RATIO * PRE_RATIO;
  localparam int CNT_W      = $clog2(MAX_PER);
  localparam int PER_W      = CNT_W + 1;

  localparam int DOM_SYS = 0;
  localparam int DOM_TMR = 1;

  typedef enum logic [1:0] {
    PM_RUN  = 2'b00,
    PM_HALT = 2'b01,
    PM_STOP = 2'b10,
    PM_STBY = 2'b11
  } pwr_mode_e;

  typedef struct packed {
    logic       tmr_pre;
    logic       sys_pre;
    logic [1:0] div_sel;
  } cfg_t;

  function automatic logic sel_is_fast(input logic [1:0] sel);
    logic f;
    case (sel)
      2'b00, 2'b01: f = 1'b0;
      default:      f = 1'b1;
    endcase
    return f;
  endfunction

  function automatic logic [PER_W-1:0] period_of(input logic fast, input logic pre);
    logic [PER_W-1:0] p;
    p = fast ? PER_W'(1) : PER_W'(BASE_RATIO);
    if (pre) p = PER_W'(p * PER_W'(PRE_RATIO));
    return p;
  endfunction

endpackage

// File: rtl/clkgen_cfg.sv
module clkgen_cfg
  import clkgen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output cfg_t             cfg_o
);

  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= cfg_t'(wdata_i);
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/clkgen_gate.sv
module clkgen_gate
  import clkgen_pkg::*;
(
  input  logic [1:0] mode_i,
  output logic       sys_run_o,
  output logic       tmr_run_o
);

  pwr_mode_e mode;

  always_comb begin
    mode      = pwr_mode_e'(mode_i);
    sys_run_o = 1'b0;
    tmr_run_o = 1'b0;
    case (mode)
      PM_RUN:  begin sys_run_o = 1'b1; tmr_run_o = 1'b1; end
      PM_HALT: tmr_run_o = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/clkgen_div.sv
module clkgen_div
  import clkgen_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic fast_i,
  input  logic pre_i,
  output logic tick_o
);

  logic [PER_W-1:0] per_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (cnt_q == CNT_W'(per_q - PER_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= period_of(1'b0, 1'b0);
    end else if (!run_i || wrap) begin
      cnt_q <= '0;
      per_q <= period_of(fast_i, pre_i);
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign tick_o = run_i && wrap;

  // R9: a strobe is followed by a low cycle unless the new period is 1
  p_single_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (!tick_o || per_q == PER_W'(1)));

  // R10: the active period only changes at a wrap or while gated
  p_period_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !wrap) |=> $stable(per_q));

  // R11: gating restarts the divider
  p_restart_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);

  p_cnt_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, cnt_q} < per_q);

endmodule

// File: rtl/clkgen_top.sv
module clkgen_top
  import clkgen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic [1:0]       pwr_mode_i,
  output logic             sys_en_o,
  output logic             tmr_en_o
);

  cfg_t            cfg;
  logic            fast;
  logic [NDOM-1:0] dom_run;
  logic [NDOM-1:0] dom_pre;
  logic [NDOM-1:0] dom_tick;

  clkgen_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  clkgen_gate u_gate (
    .mode_i    (pwr_mode_i),
    .sys_run_o (dom_run[DOM_SYS]),
    .tmr_run_o (dom_run[DOM_TMR])
  );

  assign fast             = sel_is_fast(cfg.div_sel);
  assign dom_pre[DOM_SYS] = cfg.sys_pre;
  assign dom_pre[DOM_TMR] = cfg.tmr_pre;

  for (genvar d = 0; d < NDOM; d++) begin : gen_dom
    clkgen_div u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (dom_run[d]),
      .fast_i (fast),
      .pre_i  (dom_pre[d]),
      .tick_o (dom_tick[d])
    );
  end

  assign sys_en_o = dom_tick[DOM_SYS];
  assign tmr_en_o = dom_tick[DOM_TMR];

  // R7: halt keeps the system strobe low
  p_halt_sys_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_mode_i == PM_HALT) |-> !sys_en_o);

  // R8: stop and standby silence both strobes
  p_deep_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_mode_i[1] |-> (!sys_en_o && !tmr_en_o));

  // R2: full rate in run mode gives a strobe again in the next cycle
  p_full_rate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_en_o && pwr_mode_i == PM_RUN && $stable(pwr_mode_i) && !cfg.sys_pre
     && fast && $past(fast) && !cfg_we_i) |=> sys_en_o);

endmodule

// File: tb/clkgen_top_tb_top.sv
module clkgen_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [3:0] wd = 4'h0;
  logic [1:0] mode = 2'b00;
  logic       sys_en, tmr_en;
  int         total = 0;
  int         bad = 0;

  always #10 clk = ~clk;

  clkgen_top dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_we_i    (we),
    .cfg_wdata_i (wd),
    .pwr_mode_i  (mode),
    .sys_en_o    (sys_en),
    .tmr_en_o    (tmr_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] v);
    @(negedge clk);
    we = 1'b1;
    wd = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  function automatic logic pick(input bit dom);
    return dom ? tmr_en : sys_en;
  endfunction

  // distance in cycles between two consecutive strobes of one domain
  task automatic gap(input bit dom, output int n);
    int k;
    k = 0;
    do begin step(); k++; end while (!pick(dom) && k < 100);
    n = 0;
    do begin step(); n++; end while (!pick(dom) && n < 100);
  endtask

  task automatic settle_gap(input bit dom, output int n);
    int t;
    gap(dom, t);
    gap(dom, n);
  endtask

  task automatic count_win(input int len, output int ns, output int nt);
    ns = 0;
    nt = 0;
    for (int i = 0; i < len; i++) begin
      step();
      ns += int'(sys_en);
      nt += int'(tmr_en);
    end
  endtask

  task automatic t_reset;
    int n;
    step();
    chk("R1 sys low in reset", int'(sys_en), 0);
    chk("R1 tmr low in reset", int'(tmr_en), 0);
    @(negedge clk);
    rst_n = 1'b1;
    gap(0, n); chk("R1 sys period", n, 2);
    gap(1, n); chk("R1 tmr period", n, 2);
  endtask

  task automatic t_width;
    int k;
    k = 0;
    do begin step(); k++; end while (!sys_en && k < 100);
    step();
    chk("R9 sys one cycle high", int'(sys_en), 0);
  endtask

  task automatic t_rates;
    int n;
    wr(4'b0010);
    settle_gap(0, n); chk("R2 sys full rate", n, 1);
    settle_gap(1, n); chk("R2 tmr full rate", n, 1);
    wr(4'b0001);
    settle_gap(0, n); chk("R3 sys bit0 ignored", n, 2);
    settle_gap(1, n); chk("R3 tmr bit0 ignored", n, 2);
    wr(4'b0110);
    settle_gap(0, n); chk("R4 sys pre fast", n, 16);
    settle_gap(1, n); chk("R4 tmr untouched", n, 1);
    wr(4'b0100);
    settle_gap(0, n); chk("R4 sys pre slow", n, 32);
    settle_gap(1, n); chk("R4 tmr untouched slow", n, 2);
    wr(4'b1000);
    settle_gap(1, n); chk("R5 tmr pre slow", n, 32);
    settle_gap(0, n); chk("R5 sys untouched", n, 2);
    wr(4'b1010);
    settle_gap(1, n); chk("R5 tmr pre fast", n, 16);
    settle_gap(0, n); chk("R5 sys untouched fast", n, 1);
  endtask

  task automatic t_modes;
    int ns, nt;
    wr(4'b0000);
    count_win(8, ns, nt);
    mode = 2'b00;
    count_win(40, ns, nt);
    chk("R6 run sys count", ns, 20);
    chk("R6 run tmr count", nt, 20);
    @(negedge clk); mode = 2'b01;
    count_win(40, ns, nt);
    chk("R7 halt sys count", ns, 0);
    chk("R7 halt tmr count", nt, 20);
    @(negedge clk); mode = 2'b10;
    count_win(40, ns, nt);
    chk("R8 stop sys count", ns, 0);
    chk("R8 stop tmr count", nt, 0);
    @(negedge clk); mode = 2'b11;
    count_win(40, ns, nt);
    chk("R8 standby sys count", ns, 0);
    chk("R8 standby tmr count", nt, 0);
    @(negedge clk); mode = 2'b00;
  endtask

  task automatic t_late_write;
    int k, c, n;
    wr(4'b0100);
    settle_gap(0, n);
    k = 0;
    do begin step(); k++; end while (!sys_en && k < 100);
    c = 0;
    do begin
      @(negedge clk);
      we = (c == 0);
      wd = 4'b0000;
      #1;
      c++;
    end while (!sys_en && c < 100);
    we = 1'b0;
    chk("R10 interval in progress keeps old period", c, 32);
    gap(0, n); chk("R10 new period after wrap", n, 2);
  endtask

  task automatic t_resume;
    int k;
    wr(4'b0100);
    @(negedge clk); mode = 2'b01;
    repeat (5) step();
    wr(4'b0110);
    repeat (5) step();
    @(negedge clk);
    mode = 2'b00;
    #1;
    k = 0;
    while (!sys_en && k < 100) begin step(); k++; end
    chk("R11 first strobe after resume", k, 15);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_width();
    t_rates();
    t_modes();
    t_late_write();
    t_resume();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule